// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one 32-bit timer channel clocked by the peripheral clock. Software reaches four word registers through a byte-addressed port: a reload value, the live count, a control word and an optional capture word. While the `run_i` input is high, a prescaler divides the clock by a selectable power of four. Each prescaled tick decrements the count. A tick that finds the count at zero loads the reload value instead and raises a sticky underflow flag.

The flag drives an interrupt line when the interrupt-enable bit in the control word is set. Software clears the flag by writing the control word with the flag bit at zero. Writes to reserved or unsupported control encodings are rejected, as is any access to an unmapped offset. A rejected access pulses `err_o` for one cycle and changes nothing. Counting from an external clock and input capture are not implemented. The capture word is only a plain storage register, and only when `HAS_CAPTURE` is set.

Top module: `tmr_chan`

## Requirements
- R1: After reset, the reload and count registers read 0xFFFFFFFF, the control word reads 0, and `irq_o` and `err_o` are low.
- R2: The word index is `addr` shifted right by two. Index 0 is the reload value, 1 is the count, 2 is control, and 3 is capture when `HAS_CAPTURE` is set. `rdata` combinationally shows the addressed register. Writing the count loads it directly, and writing the reload value does not change the count.
- R3: Control bits [2:0] pick the divide ratio: 0 gives /4, 1 gives /16, 2 gives /64, 3 gives /256 and 4 gives /1024. The count changes once per ratio cycles of the clock while `run_i` is high. Codes 6 and 7 (external clock, only when `HAS_EXTCLK` is set) produce no ticks.
- R4: A tick with a nonzero count decrements it. A tick with the count at zero loads the reload value on that same tick and sets the underflow flag.
- R5: While `run_i` is low, the count holds and the underflow flag never sets.
- R6: A control read returns the stored bits [7:0], with bit 8 showing the underflow flag. A control write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves the flag unchanged.
- R7: A control write is rejected when any of these holds: bits [31:10] are nonzero; the ratio code is 5; the ratio code is 6 or 7 without external clock support; bits [4:3] are nonzero without external clock support; bits [7:6] equal 1; bits [7:6] or bit 9 are nonzero without capture support. A rejected write raises `err_o` for one cycle and leaves all registers unchanged.
- R8: A read or write to an unmapped word (index above 3, or index 3 without capture) raises `err_o` for one cycle. Such a read returns 0.
- R9: `irq_o` is the underflow flag ANDed with control bit 5, registered. It follows either input one cycle later.
- R10: Every accepted control write restarts the prescaler phase. The first tick afterwards comes a full ratio period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Start/stop for counting |
| rd_en | input | 1 | Read strobe, used only for error detection |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq_o | output | 1 | Underflow interrupt |
| err_o | output | 1 | One-cycle pulse on an illegal access |

## Verification
A prescaler whose phase counter is off by one shows up at the ports within a single ratio period. The count then changes one cycle early or late relative to the control write, so the bench samples the count on the exact cycle before the expected tick and on the tick itself. A count or flag that is wrong at underflow appears on the same cycle as the reload, both in the count read and in bit 8 of the control read. A wrong interrupt path appears one cycle later on `irq_o`. A register that is wrongly updated on a rejected write stays visible until the next legal write, so every rejected write is followed by a read-back.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW          = 32,
  parameter int AW          = 6,
  parameter bit HAS_CAPTURE = 1'b0,
  parameter bit HAS_EXTCLK  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o,
  output logic          err_o
);
  localparam int PW = 10;
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] W_RLD = WW'(0);
  localparam logic [WW-1:0] W_CNT = WW'(1);
  localparam logic [WW-1:0] W_CTL = WW'(2);
  localparam logic [WW-1:0] W_CAP = WW'(3);

  logic [DW-1:0] reload_q, cnt_q, cap_rd;
  logic [7:0]    ctrl_q;
  logic          flag_q, irq_q, err_q;
  logic [PW-1:0] pre_q, pre_lim;

  logic [WW-1:0] word;
  logic [2:0]    psc_w;
  logic [1:0]    edge_w, cape_w;
  logic          ctrl_bad, word_ok, acc, bad_acc;
  logic          ctrl_wr, cnt_wr, rld_wr, cap_wr;
  logic          ext_sel, tick, unf;

  assign word   = addr[AW-1:2];
  assign psc_w  = wdata[2:0];
  assign edge_w = wdata[4:3];
  assign cape_w = wdata[7:6];

  assign ctrl_bad = (|wdata[DW-1:10])
                  | (psc_w == 3'd5)
                  | (psc_w[2] & psc_w[1] & !HAS_EXTCLK)
                  | ((edge_w != 2'd0) & !HAS_EXTCLK)
                  | (cape_w == 2'd1)
                  | ((cape_w != 2'd0) & !HAS_CAPTURE)
                  | (wdata[9] & !HAS_CAPTURE);

  assign word_ok = (word == W_RLD) | (word == W_CNT) | (word == W_CTL)
                 | ((word == W_CAP) & HAS_CAPTURE);
  assign acc     = rd_en | wr_en;
  assign bad_acc = acc & (!word_ok | (wr_en & (word == W_CTL) & ctrl_bad));

  assign ctrl_wr = wr_en & (word == W_CTL) & !ctrl_bad;
  assign cnt_wr  = wr_en & (word == W_CNT);
  assign rld_wr  = wr_en & (word == W_RLD);
  assign cap_wr  = wr_en & (word == W_CAP) & HAS_CAPTURE;

  assign ext_sel = ctrl_q[2] & ctrl_q[1];

  always_comb begin
    case (ctrl_q[2:0])
      3'd0:    pre_lim = PW'(3);
      3'd1:    pre_lim = PW'(15);
      3'd2:    pre_lim = PW'(63);
      3'd3:    pre_lim = PW'(255);
      default: pre_lim = PW'(1023);
    endcase
  end

  assign tick = run_i & !ext_sel & !ctrl_wr & (pre_q == pre_lim);
  assign unf  = tick & !cnt_wr & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_q <= '0;
    else if (ctrl_wr)          pre_q <= '0;
    else if (run_i & !ext_sel) pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_wr) cnt_q <= wdata;
    else if (unf)    cnt_q <= reload_q;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reload_q <= '1;
    else if (rld_wr) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata[7:0];
      if (ctrl_wr & !wdata[8]) flag_q <= 1'b0;
      else if (unf)            flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      irq_q <= flag_q & ctrl_q[5];
      err_q <= bad_acc;
    end
  end

  generate
    if (HAS_CAPTURE) begin : g_cap
      logic [DW-1:0] cap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap_q <= '0;
        else if (cap_wr) cap_q <= wdata;
      end
      assign cap_rd = cap_q;
    end else begin : g_nocap
      assign cap_rd = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (word == W_RLD)      rdata = reload_q;
    else if (word == W_CNT) rdata = cnt_q;
    else if (word == W_CTL) rdata = DW'({flag_q, ctrl_q});
    else if (word == W_CAP) rdata = cap_rd;
  end

  assign irq_o = irq_q;
  assign err_o = err_q;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr) |=> $stable(cnt_q)); // R5
  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(run_i)); // R5
  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q == '0) |=> (cnt_q == $past(reload_q) && flag_q)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_acc) |=> ($stable(ctrl_q) && $stable(reload_q) && err_o)); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && ctrl_q[5]) |=> irq_o); // R9
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (pre_q == '0)); // R10
endmodule

// File: tb/tmr_chan_tb.sv
`timescale 1ns/1ps
module tmr_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, err_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  tmr_chan u_dut (.clk(clk), .rst_n(rst_n), .run_i(run_i), .rd_en(rd_en),
                  .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
                  .irq_o(irq_o), .err_o(err_o));

  always #2.5 clk = ~clk;

  // {byte address, write data, expected read-back, expected error}
  localparam logic [72:0] VEC [12] = '{
    {8'h00, 32'h12345678, 32'h12345678, 1'b0},  // R2
    {8'h04, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0},  // R2
    {8'h08, 32'h00000024, 32'h00000024, 1'b0},  // R6
    {8'h08, 32'h00000023, 32'h00000023, 1'b0},  // R6
    {8'h08, 32'h00000105, 32'h00000023, 1'b1},  // R7 ratio 5
    {8'h08, 32'h00000400, 32'h00000023, 1'b1},  // R7 high bits
    {8'h08, 32'h00000008, 32'h00000023, 1'b1},  // R7 edge field
    {8'h08, 32'h00000200, 32'h00000023, 1'b1},  // R7 bit 9
    {8'h08, 32'h00000040, 32'h00000023, 1'b1},  // R7 capture enable
    {8'h08, 32'h00000006, 32'h00000023, 1'b1},  // R7 ratio 6
    {8'h08, 32'h00000100, 32'h00000000, 1'b0},  // R6 bit 8 set, flag stays 0
    {8'h0C, 32'h0000ABCD, 32'h00000000, 1'b1}   // R8 capture absent
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a[5:0]; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] v);
    addr = a[5:0];
    #0.5;
    v = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    #12 rst_n = 1'b1;
    @(negedge clk);
    peek(8'h00, v); check("R1 reload", v, 32'hFFFFFFFF);
    peek(8'h04, v); check("R1 count", v, 32'hFFFFFFFF);
    peek(8'h08, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 err", {31'b0, err_o}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][72:65], VEC[i][64:33]);
      check("R2/R6/R7/R8 err", {31'b0, err_o}, {31'b0, VEC[i][0]});
      peek(VEC[i][72:65], v);
      check("R2/R6/R7/R8 readback", v, VEC[i][32:1]);
    end

    // R8: unmapped read strobe
    @(negedge clk); addr = 6'h10; rd_en = 1'b1;
    #0.5 check("R8 read zero", rdata, 32'h0);
    @(negedge clk); rd_en = 1'b0;
    check("R8 read err", {31'b0, err_o}, 32'h1);
    @(negedge clk);
    check("R8 err one cycle", {31'b0, err_o}, 32'h0);

    // R4 R9: countdown at /4 with reload
    wr(8'h00, 32'd5); wr(8'h04, 32'd2); wr(8'h08, 32'h20);
    run_i = 1'b1;
    repeat (11) @(negedge clk);
    peek(8'h04, v); check("R4 count before underflow", v, 32'd0);
    peek(8'h08, v); check("R4 flag before underflow", v, 32'h20);
    @(negedge clk);
    peek(8'h04, v); check("R4 reload on underflow", v, 32'd5);
    peek(8'h08, v); check("R4 R6 flag read", v, 32'h120);
    check("R9 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check("R9 irq raised", {31'b0, irq_o}, 32'h1);
    run_i = 1'b0;

    // R6: write 1 keeps flag, write 0 clears
    wr(8'h08, 32'h120);
    peek(8'h08, v); check("R6 flag kept", v, 32'h120);
    wr(8'h08, 32'h20);
    peek(8'h08, v); check("R6 flag cleared", v, 32'h20);
    check("R9 irq lags clear", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R9 irq dropped", {31'b0, irq_o}, 32'h0);

    // R9: flag with interrupt disabled, then enabled
    wr(8'h04, 32'd0); wr(8'h08, 32'h00);
    run_i = 1'b1;
    repeat (4) @(negedge clk);
    run_i = 1'b0;
    peek(8'h08, v); check("R4 flag set with ie off", v, 32'h100);
    @(negedge clk);
    check("R9 irq masked", {31'b0, irq_o}, 32'h0);
    wr(8'h08, 32'h120);
    @(negedge clk);
    check("R9 irq after enable", {31'b0, irq_o}, 32'h1);
    wr(8'h08, 32'h00);

    // R5: hold while stopped
    wr(8'h04, 32'd0);
    repeat (40) @(negedge clk);
    peek(8'h04, v); check("R5 count held", v, 32'd0);
    peek(8'h08, v); check("R5 no flag while stopped", v, 32'h0);
    wr(8'h04, 32'd7); wr(8'h00, 32'd99);
    peek(8'h04, v); check("R2 reload write leaves count", v, 32'd7);

    // R10: phase restart
    wr(8'h04, 32'd10); wr(8'h08, 32'h00);
    run_i = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h08, 32'h00);
    repeat (3) @(negedge clk);
    peek(8'h04, v); check("R10 no early tick", v, 32'd10);
    @(negedge clk);
    peek(8'h04, v); check("R10 tick after full period", v, 32'd9);
    run_i = 1'b0;

    // R3: ratios /16 /64 /256 /1024
    for (int p = 1; p <= 4; p++) begin
      int lim;
      lim = 4 << (2 * p);
      wr(8'h04, 32'd1); wr(8'h08, p);
      run_i = 1'b1;
      repeat (lim - 1) @(negedge clk);
      peek(8'h04, v); check("R3 before tick", v, 32'd1);
      @(negedge clk);
      peek(8'h04, v); check("R3 on tick", v, 32'd0);
      run_i = 1'b0;
    end

    // R7: rejected write pulse width and no state change
    wr(8'h08, 32'h0001_0000);
    check("R7 err pulse", {31'b0, err_o}, 32'h1);
    peek(8'h08, v); check("R7 control kept", v, 32'h4);
    @(negedge clk);
    check("R7 err one cycle", {31'b0, err_o}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule